// File: doc/BRIEF.md
# Maskable Interrupt Router with Wake Request

The block collects level-sensitive interrupt requests from up to 32 sources. Each request is held while its source drives it, and is released when the source lets go. A per-line enable mask selects the lines that may interrupt the processor. A per-line routing register sends each enabled line to either a normal interrupt output or a fast interrupt output. A global enable bit must be set before either output can assert.

The lowest lines carry the dedicated general-purpose pin interrupts. The line just above them carries the summary of the pin group. The remaining lines are internal sources that clear themselves. A wake request is raised while the system sleeps, and only a subset of sources can raise it: each dedicated pin line, the pin-group summary, and one real-time-clock alarm line. Each of these has its own wake-enable bit, and wake ignores the interrupt mask.

Software uses a small register bus. It writes the configuration and reads back three things: the raw request vector, the masked vector, and the index of the lowest-numbered enabled request that is routed to the normal output.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After synchronous reset the mask, routing, wake-enable and global-enable registers are all 0, all three outputs are low, and the index register reads NLINES.
- R2: Writing address 0 (mask), 1 (routing, bit 1 = fast), 2 (wake-enable) or 3 (global enable, bit 0) stores the value, and reading the same address returns it in the cycle after the read address is presented.
- R3: Address 4 reads the raw request vector whatever the mask is, and address 5 reads the raw vector ANDed with the mask.
- R4: irq_norm_o is high exactly when the global enable is 1 and some request is both enabled by the mask and has routing bit 0.
- R5: irq_fast_o is high exactly when the global enable is 1 and some request is both enabled by the mask and has routing bit 1.
- R6: While the global enable is 0, neither interrupt output asserts, whatever the requests and mask are.
- R7: Address 6 reads the index of the lowest-numbered request that is enabled by the mask and routed normal, or NLINES when there is none. The global enable does not affect it.
- R8: wake_o is high when any wake source is requesting and has its wake-enable bit set, independent of the mask and the global enable. The wake-enable bit positions are: bits 0..NLOW-1 for lines 0..NLOW-1, bit NLOW for line NLOW (the pin-group summary), and bit NLOW+1 for line RTC_LINE.
- R9: No other line can cause wake. Wake-enable bits above NLOW+1 are not stored and read as 0.
- R10: Clearing mask bits 0..NLOW silences every pin-derived request on both interrupt outputs and leaves the other lines working.
- R11: Writes to addresses 4 to 7 change no configuration register.
- R12: A change on the requests shows on the interrupt and wake outputs after exactly two rising clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NLINES | Level interrupt requests |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| irq_norm_o | output | 1 | Normal interrupt output |
| irq_fast_o | output | 1 | Fast interrupt output |
| wake_o | output | 1 | Wake request output |

## Verification
The bench builds the block with NLINES=12, NLOW=4 and RTC_LINE=9. At that size all 4096 request patterns can be swept under each of several mask, routing, wake-enable and global-enable settings. Every sweep step compares both interrupt outputs, the wake output and the lowest-index register with values the bench computes arithmetically. This brings every priority position, including the empty case, within reach. It also covers every combination of the wake sources, the cleared pin-mask case, and the two-edge latency.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_MASK   = 3'd0,
    RA_ROUTE  = 3'd1,
    RA_WAKE   = 3'd2,
    RA_CTRL   = 3'd3,
    RA_RAW    = 3'd4,
    RA_MASKED = 3'd5,
    RA_INDEX  = 3'd6,
    RA_SPARE  = 3'd7
  } reg_addr_e;

  function automatic logic is_writable(reg_addr_e a);
    return (a == RA_MASK) || (a == RA_ROUTE) || (a == RA_WAKE) || (a == RA_CTRL);
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_steer_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int WAKE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  reg_addr_e         addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [NLINES-1:0] mask_q,
  output logic [NLINES-1:0] route_q,
  output logic [WAKE_W-1:0] wake_en_q,
  output logic              ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      route_q   <= '0;
      wake_en_q <= '0;
      ctrl_q    <= 1'b0;
    end else if (we) begin
      case (addr)
        RA_MASK:  mask_q    <= wdata[NLINES-1:0];
        RA_ROUTE: route_q   <= wdata[NLINES-1:0];
        RA_WAKE:  wake_en_q <= wdata[WAKE_W-1:0];
        RA_CTRL:  ctrl_q    <= wdata[0];
        default:  ;
      endcase
    end
  end

  assert_reset_cfg_R1: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '0 && route_q == '0 && wake_en_q == '0 && !ctrl_q));

  assert_ro_write_R11: assert property (@(posedge clk) disable iff (rst)
    (we && !is_writable(addr)) |=> ($stable(mask_q) && $stable(route_q) &&
                                    $stable(wake_en_q) && $stable(ctrl_q)));
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NLINES   = 32,
  parameter int NLOW     = 8,
  parameter int RTC_LINE = 20,
  parameter int WAKE_W   = NLOW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_i,
  input  logic [NLINES-1:0] mask_i,
  input  logic [NLINES-1:0] route_i,
  input  logic [WAKE_W-1:0] wake_en_i,
  input  logic              ctrl_i,
  output logic [NLINES-1:0] pend_q,
  output logic [NLINES-1:0] masked_o,
  output logic [NLINES-1:0] norm_vec_o,
  output logic              norm_q,
  output logic              fast_q,
  output logic              wake_q
);
  logic [NLINES-1:0] fast_vec;
  logic [WAKE_W-1:0] wake_src;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= req_i;
  end

  assign masked_o   = pend_q & mask_i;
  assign norm_vec_o = masked_o & ~route_i;
  assign fast_vec   = masked_o & route_i;

  generate
    for (genvar g = 0; g < NLOW; g++) begin : g_low_wake
      assign wake_src[g] = pend_q[g];
    end
  endgenerate
  assign wake_src[NLOW]   = pend_q[NLOW];
  assign wake_src[NLOW+1] = pend_q[RTC_LINE];

  always_ff @(posedge clk) begin
    if (rst) begin
      norm_q <= 1'b0;
      fast_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      norm_q <= ctrl_i & (|norm_vec_o);
      fast_q <= ctrl_i & (|fast_vec);
      wake_q <= |(wake_src & wake_en_i);
    end
  end

  assert_pend_follows_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pend_q == $past(req_i)));

  assert_ctrl_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrl_i |=> (!norm_q && !fast_q));

  assert_wake_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (wake_en_i == '0) |=> !wake_q);

  assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |=> (!norm_q && !fast_q));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NLINES = 32,
  parameter int IDX_W  = $clog2(NLINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] vec_i,
  output logic [IDX_W-1:0]  idx_q
);
  logic [IDX_W-1:0] idx_n;

  always_comb begin
    idx_n = IDX_W'(NLINES);
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_n = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= IDX_W'(NLINES);
    else     idx_q <= idx_n;
  end

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    idx_q <= IDX_W'(NLINES));
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int NLINES   = 32,
  parameter int NLOW     = 8,
  parameter int RTC_LINE = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_norm_o,
  output logic              irq_fast_o,
  output logic              wake_o
);
  localparam int WAKE_W = NLOW + 2;
  localparam int IDX_W  = $clog2(NLINES + 1);

  reg_addr_e         addr_e;
  logic [NLINES-1:0] mask_q, route_q, pend_q, masked, norm_vec;
  logic [WAKE_W-1:0] wake_en_q;
  logic              ctrl_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BUS_W-1:0]  rdata_n;

  assign addr_e = reg_addr_e'(bus_addr);

  irq_cfg_regs #(.NLINES(NLINES), .WAKE_W(WAKE_W)) u_cfg (
    .clk(clk), .rst(rst), .we(bus_we), .addr(addr_e), .wdata(bus_wdata),
    .mask_q(mask_q), .route_q(route_q), .wake_en_q(wake_en_q), .ctrl_q(ctrl_q)
  );

  irq_route #(.NLINES(NLINES), .NLOW(NLOW), .RTC_LINE(RTC_LINE), .WAKE_W(WAKE_W)) u_route (
    .clk(clk), .rst(rst), .req_i(req_i), .mask_i(mask_q), .route_i(route_q),
    .wake_en_i(wake_en_q), .ctrl_i(ctrl_q), .pend_q(pend_q), .masked_o(masked),
    .norm_vec_o(norm_vec), .norm_q(irq_norm_o), .fast_q(irq_fast_o), .wake_q(wake_o)
  );

  irq_prio_enc #(.NLINES(NLINES), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst(rst), .vec_i(norm_vec), .idx_q(idx_q)
  );

  always_comb begin
    case (addr_e)
      RA_MASK:   rdata_n = BUS_W'(mask_q);
      RA_ROUTE:  rdata_n = BUS_W'(route_q);
      RA_WAKE:   rdata_n = BUS_W'(wake_en_q);
      RA_CTRL:   rdata_n = BUS_W'(ctrl_q);
      RA_RAW:    rdata_n = BUS_W'(pend_q);
      RA_MASKED: rdata_n = BUS_W'(masked);
      RA_INDEX:  rdata_n = BUS_W'(idx_q);
      default:   rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rdata_n;
  end

  assert_norm_has_index_R7: assert property (@(posedge clk) disable iff (rst)
    irq_norm_o |-> (idx_q != IDX_W'(NLINES)));

  assert_outputs_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_norm_o && !irq_fast_o && !wake_o));
endmodule

// File: tb/irq_steer_ctrl_test.sv
module irq_steer_ctrl_test;
  localparam int NL = 12;
  localparam int NLOW = 4;
  localparam int RTC = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] req = '0;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_norm, irq_fast, wake;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_steer_ctrl #(.NLINES(NL), .NLOW(NLOW), .RTC_LINE(RTC)) uut (
    .clk(clk), .rst(rst), .req_i(req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_norm_o(irq_norm),
    .irq_fast_o(irq_fast), .wake_o(wake)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  function automatic int low_idx(input logic [NL-1:0] v);
    for (int i = 0; i < NL; i++) if (v[i]) return i;
    return NL;
  endfunction

  task automatic sweep(input logic [NL-1:0] m, input logic [NL-1:0] lv,
                       input logic [NLOW+1:0] wk, input logic en, input string tag);
    logic [31:0] d;
    wr(3'd0, 32'(m)); wr(3'd1, 32'(lv)); wr(3'd2, 32'(wk)); wr(3'd3, 32'(en));
    rd(3'd0, d); check({"R2 mask ", tag}, d, 32'(m));
    rd(3'd1, d); check({"R2 route ", tag}, d, 32'(lv));
    rd(3'd2, d); check({"R2 wake ", tag}, d, 32'(wk));
    rd(3'd3, d); check({"R2 ctrl ", tag}, d, 32'(en));
    @(negedge clk); bus_addr = 3'd6;
    for (int p = 0; p < (1 << NL); p++) begin
      logic [NL-1:0] r, nv, fv;
      logic ew;
      r = NL'(p);
      nv = r & m & ~lv;
      fv = r & m & lv;
      ew = |({r[RTC], r[NLOW], r[NLOW-1:0]} & wk);
      req = r;
      repeat (3) @(negedge clk);
      check({"R4 norm ", tag}, 32'(irq_norm), 32'(en & (|nv)));
      check({"R5 fast ", tag}, 32'(irq_fast), 32'(en & (|fv)));
      check({"R8 wake ", tag}, 32'(wake), 32'(ew));
      check({"R7 index ", tag}, bus_rdata, 32'(low_idx(nv)));
    end
    req = '0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 norm", 32'(irq_norm), 0);
    check("R1 fast", 32'(irq_fast), 0);
    check("R1 wake", 32'(wake), 0);
    rd(3'd0, d); check("R1 mask", d, 0);
    rd(3'd1, d); check("R1 route", d, 0);
    rd(3'd2, d); check("R1 wake_en", d, 0);
    rd(3'd3, d); check("R1 ctrl", d, 0);
    rd(3'd6, d); check("R1 index", d, NL);

    // R9: wake bits above NLOW+1 not stored
    wr(3'd2, 32'hFFF); rd(3'd2, d); check("R9 wake width", d, 32'h3F);
    // R9: a non-wake line cannot wake
    @(negedge clk); req = 12'h800; repeat (3) @(negedge clk);
    check("R9 no wake from line 11", 32'(wake), 0);
    req = '0;

    // R3: raw and masked reads
    wr(3'd0, 32'h0F0);
    @(negedge clk); req = 12'hA5A; @(negedge clk);
    rd(3'd4, d); check("R3 raw", d, 32'hA5A);
    rd(3'd5, d); check("R3 masked", d, 32'h050);

    // R11: writes to read-only addresses
    for (int a = 4; a < 8; a++) wr(3'(a), 32'hFFFF_FFFF);
    rd(3'd0, d); check("R11 mask kept", d, 32'h0F0);
    rd(3'd1, d); check("R11 route kept", d, 0);
    rd(3'd2, d); check("R11 wake kept", d, 32'h3F);
    rd(3'd3, d); check("R11 ctrl kept", d, 0);
    req = '0;

    // R12: two-edge latency
    wr(3'd0, 32'hFFF); wr(3'd1, 0); wr(3'd3, 1);
    repeat (3) @(negedge clk);
    req = 12'h004;
    @(negedge clk); check("R12 one edge", 32'(irq_norm), 0);
    check("R12 wake one edge", 32'(wake), 0);
    @(negedge clk); check("R12 two edges", 32'(irq_norm), 1);
    check("R12 wake two edges", 32'(wake), 1);
    req = '0;

    sweep(12'hFFF, 12'h000, 6'h00, 1'b1, "all normal");
    sweep(12'hA5C, 12'h3C3, 6'h3F, 1'b1, "mixed");
    sweep(12'hFFF, 12'hFFF, 6'h15, 1'b0, "R6 disabled");
    sweep(12'hFFF & ~12'h01F, 12'h0F0, 6'h2A, 1'b1, "R10 gpio cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule